// File: doc/BRIEF.md
# Generalized Reverse, OR-Combine and Shuffle Unit

This unit rearranges the bits of a 64-bit word with a shared butterfly network. It supports four operations. Generalized reverse exchanges neighbouring bit groups. OR-combine merges each group with its exchanged copy. Shuffle interleaves groups, and unshuffle undoes the interleave. Each bit of a control amount switches on one stage, and each stage works on groups of a power-of-two size.

A caller presents the data word, the amount and an operation code together with a valid strobe. The result is captured in a register and comes out one cycle later with its own valid flag. The amount may come from a register or an immediate. Bits of the amount that the chosen operation does not use are masked off.

Top module: `bperm_unit`

## Requirements
- R1: The operation code is 0 for reverse, 1 for OR-combine, 2 for shuffle and 3 for unshuffle. When `in_valid` is high at a clock edge, `out_data` holds that request's result after the edge and `out_valid` is high.
- R2: Reverse stage k (amount bit k, k = 0..5) swaps every pair of adjacent 2^k-bit groups. With amount 63 the output is the input with its bit order fully reversed.
- R3: Reverse with amount 56 reverses the byte order of the word.
- R4: OR-combine uses the same stages as reverse, but each enabled stage ORs the swapped value into the current value. Every input 1 bit stays set. For example, amount 7 spreads a single set bit over its whole byte.
- R5: Shuffle uses amount bits 4..0 to enable stages of group size 16, 8, 4, 2 and 1, applied in that order. Within each block of 4N bits, a stage exchanges the second and third N-bit groups.
- R6: Unshuffle applies the same stages in the order 1, 2, 4, 8, 16, so that unshuffle(shuffle(x, a), a) equals x for every amount a.
- R7: Shuffle and unshuffle ignore amount bit 5. An amount a and an amount a+32 give the same result.
- R8: While reset is held, and after it is released until the first valid request, `out_valid` is 0 and `out_data` is 0.
- R9: A cycle with `in_valid` low drives `out_valid` low on the next cycle and leaves `out_data` unchanged.
- R10: An amount of 0 returns the input word unchanged for all four operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code (see R1) |
| in_amt | input | 6 | Control amount, one bit per stage |
| in_data | input | 64 | Word to rearrange |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Registered result |

## Verification
The bench targets the points where the four operations diverge while sharing one network.

- **Stage order.** Shuffle must run its stages from the largest group down to the smallest. A network run in the wrong order still passes single-stage cases, but fails the round trip of unshuffle after shuffle once two stages are enabled.
- **Ignored amount bit.** A design that lets amount bit 5 reach the shuffle paths gives results that differ between amounts 31 and 63.
- **OR-combine merging.** An OR-combine stage that replaces the word instead of merging into it drops the original bits. That makes the single-bit byte-fill case return one moved bit instead of a full byte.
- **Full and byte reversal.** These catch a stage whose masks are swapped or misplaced.
- **Hold behaviour.** Idle cycles between requests check that the output register neither updates nor loses its value.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

    typedef enum logic [1:0] {
        OP_GREV   = 2'd0,
        OP_GORC   = 2'd1,
        OP_SHFL   = 2'd2,
        OP_UNSHFL = 2'd3
    } bperm_op_e;

endpackage

// File: rtl/bperm_swap_stage.sv
// One butterfly stage: exchanges adjacent groups of 2^STAGE bits, or merges
// the exchanged copy into the word when merge is set.
module bperm_swap_stage #(
    parameter int XLEN  = 64,
    parameter int STAGE = 0
) (
    input  logic [XLEN-1:0] din,
    input  logic            en,
    input  logic            merge,
    output logic [XLEN-1:0] dout
);
    localparam int SPAN = 1 << STAGE;

    function automatic logic [XLEN-1:0] low_groups();
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) begin
            m[i] = ((i >> STAGE) & 1) == 0;
        end
        return m;
    endfunction

    localparam logic [XLEN-1:0] LO_MASK = low_groups();

    logic [XLEN-1:0] swapped;

    always_comb begin
        swapped = ((din & LO_MASK) << SPAN) | ((din & ~LO_MASK) >> SPAN);
        if (!en) begin
            dout = din;
        end else if (merge) begin
            dout = din | swapped;
        end else begin
            dout = swapped;
        end
    end

endmodule

// File: rtl/bperm_shuffle_stage.sv
// One shuffle stage: inside each block of 4N bits, exchanges the second and
// third N-bit groups; the outer groups stay in place.
module bperm_shuffle_stage #(
    parameter int XLEN  = 64,
    parameter int STAGE = 0
) (
    input  logic [XLEN-1:0] din,
    input  logic            en,
    output logic [XLEN-1:0] dout
);
    localparam int SPAN = 1 << STAGE;

    function automatic logic [XLEN-1:0] group_sel(input int code);
        logic [XLEN-1:0] m;
        for (int i = 0; i < XLEN; i++) begin
            m[i] = ((i >> STAGE) & 3) == code;
        end
        return m;
    endfunction

    localparam logic [XLEN-1:0] UP_MASK = group_sel(2);
    localparam logic [XLEN-1:0] DN_MASK = group_sel(1);

    always_comb begin
        if (en) begin
            dout = (din & ~(UP_MASK | DN_MASK))
                 | ((din << SPAN) & UP_MASK)
                 | ((din >> SPAN) & DN_MASK);
        end else begin
            dout = din;
        end
    end

endmodule

// File: rtl/bperm_core.sv
// Combinational network: one butterfly chain for reverse and OR-combine,
// two shuffle chains built from the same stage in opposite orders.
module bperm_core
    import bperm_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         data,
    input  logic [$clog2(XLEN)-1:0] amt,
    input  bperm_op_e               op,
    output logic [XLEN-1:0]         result
);
    localparam int AMT_W = $clog2(XLEN);
    localparam int SHF_W = AMT_W - 1;

    logic            merge;
    logic [XLEN-1:0] bf_chain [0:AMT_W];
    logic [XLEN-1:0] zip_chain [0:SHF_W];
    logic [XLEN-1:0] unzip_chain [0:SHF_W];

    assign merge          = (op == OP_GORC);
    assign bf_chain[0]    = data;
    assign zip_chain[0]   = data;
    assign unzip_chain[0] = data;

    for (genvar g = 0; g < AMT_W; g++) begin : g_bfly
        bperm_swap_stage #(.XLEN(XLEN), .STAGE(g)) u_stage (
            .din   (bf_chain[g]),
            .en    (amt[g]),
            .merge (merge),
            .dout  (bf_chain[g+1])
        );
    end

    // Shuffle: largest group first.
    for (genvar g = 0; g < SHF_W; g++) begin : g_zip
        bperm_shuffle_stage #(.XLEN(XLEN), .STAGE(SHF_W-1-g)) u_stage (
            .din  (zip_chain[g]),
            .en   (amt[SHF_W-1-g]),
            .dout (zip_chain[g+1])
        );
    end

    // Unshuffle: smallest group first.
    for (genvar g = 0; g < SHF_W; g++) begin : g_unzip
        bperm_shuffle_stage #(.XLEN(XLEN), .STAGE(g)) u_stage (
            .din  (unzip_chain[g]),
            .en   (amt[g]),
            .dout (unzip_chain[g+1])
        );
    end

    always_comb begin
        unique case (op)
            OP_GREV, OP_GORC: result = bf_chain[AMT_W];
            OP_SHFL:          result = zip_chain[SHF_W];
            OP_UNSHFL:        result = unzip_chain[SHF_W];
            default:          result = data;
        endcase
    end

endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
    import bperm_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int AMT_W = $clog2(XLEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [AMT_W-1:0] in_amt,
    input  logic [XLEN-1:0]  in_data,
    output logic             out_valid,
    output logic [XLEN-1:0]  out_data
);
    bperm_op_e       op_sel;
    logic [XLEN-1:0] net_result;

    assign op_sel = bperm_op_e'(in_op);

    bperm_core #(.XLEN(XLEN)) u_core (
        .data   (in_data),
        .amt    (in_amt),
        .op     (op_sel),
        .result (net_result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= net_result;
            end
        end
    end

    function automatic logic [XLEN-1:0] flip_bits(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = v[XLEN-1-i];
        end
        return r;
    endfunction

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    assert_full_reverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd0 && in_amt == '1)
        |=> out_data == flip_bits($past(in_data)));

    assert_gorc_keeps_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'd1)
        |=> ((out_data & $past(in_data)) == $past(in_data)));

    assert_permute_popcount_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'd1)
        |=> $countones(out_data) == $countones($past(in_data)));

    assert_zero_amount_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_amt == '0) |=> out_data == $past(in_data));

endmodule

// File: tb/tb_bperm_unit.sv
module tb_bperm_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [5:0]  in_amt;
    logic [63:0] in_data;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bperm_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_op     (in_op),
        .in_amt    (in_amt),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [63:0] lo_mask(input int k);
        case (k)
            0: return 64'h5555555555555555;
            1: return 64'h3333333333333333;
            2: return 64'h0F0F0F0F0F0F0F0F;
            3: return 64'h00FF00FF00FF00FF;
            4: return 64'h0000FFFF0000FFFF;
            default: return 64'h00000000FFFFFFFF;
        endcase
    endfunction

    function automatic logic [63:0] ref_bfly(input logic [63:0] x, input logic [5:0] a, input bit orm);
        logic [63:0] v = x;
        for (int k = 0; k < 6; k++) begin
            if (a[k]) begin
                logic [63:0] s;
                s = ((v & lo_mask(k)) << (1 << k)) | ((v & ~lo_mask(k)) >> (1 << k));
                v = orm ? (v | s) : s;
            end
        end
        return v;
    endfunction

    function automatic logic [63:0] zstage(input logic [63:0] x, input int n);
        logic [63:0] ml, mr;
        case (n)
            16: begin ml = 64'h0000ffff00000000; mr = 64'h00000000ffff0000; end
            8:  begin ml = 64'h00ff000000ff0000; mr = 64'h0000ff000000ff00; end
            4:  begin ml = 64'h0f000f000f000f00; mr = 64'h00f000f000f000f0; end
            2:  begin ml = 64'h3030303030303030; mr = 64'h0c0c0c0c0c0c0c0c; end
            default: begin ml = 64'h4444444444444444; mr = 64'h2222222222222222; end
        endcase
        return (x & ~(ml | mr)) | ((x << n) & ml) | ((x >> n) & mr);
    endfunction

    function automatic logic [63:0] ref_zip(input logic [63:0] x, input logic [5:0] a, input bit inv);
        logic [63:0] v = x;
        for (int j = 0; j < 5; j++) begin
            int k;
            k = inv ? j : 4 - j;
            if (a[k]) v = zstage(v, 1 << k);
        end
        return v;
    endfunction

    function automatic logic [63:0] ref_op(input logic [1:0] op, input logic [5:0] a, input logic [63:0] x);
        case (op)
            2'd0: return ref_bfly(x, a, 1'b0);
            2'd1: return ref_bfly(x, a, 1'b1);
            2'd2: return ref_zip(x, a, 1'b0);
            default: return ref_zip(x, a, 1'b1);
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one request, then samples its result one cycle later.
    task automatic run(input string req, input logic [1:0] op, input logic [5:0] a,
                       input logic [63:0] x, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_amt = a; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x, rev, y;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_amt = '0; in_data = '0;
        repeat (3) @(negedge clk);
        check("R8 reset valid", {63'd0, out_valid}, 64'd0);
        check("R8 reset data", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {63'd0, out_valid}, 64'd0);

        x = 64'h0123456789ABCDEF;
        for (int i = 0; i < 64; i++) rev[i] = x[63-i];
        run("R2 full reverse", 2'd0, 6'd63, x, rev);
        run("R2 single stage", 2'd0, 6'd1, 64'h1, 64'h2);
        run("R3 byte reverse", 2'd0, 6'd56, x, 64'hEFCDAB8967452301);
        run("R4 byte fill", 2'd1, 6'd7, 64'h0000000000000100, 64'h000000000000FF00);
        run("R4 full fill", 2'd1, 6'd63, 64'h8, 64'hFFFFFFFFFFFFFFFF);
        run("R5 full shuffle", 2'd2, 6'd31, 64'h00000000FFFFFFFF, 64'h5555555555555555);
        run("R6 full unshuffle", 2'd3, 6'd31, 64'h5555555555555555, 64'h00000000FFFFFFFF);
        for (int op = 0; op < 4; op++)
            run("R10 zero amount", 2'(op), 6'd0, x, x);

        // R7: bit 5 ignored by the shuffle paths
        run("R7 shfl bit5", 2'd2, 6'd37, x, ref_op(2'd2, 6'd5, x));
        run("R7 unshfl bit5", 2'd3, 6'd63, x, ref_op(2'd3, 6'd31, x));

        // R9: an idle cycle keeps the data and drops valid
        run("R9 setup", 2'd0, 6'd8, x, ref_op(2'd0, 6'd8, x));
        @(negedge clk);
        in_valid = 1'b0; in_data = ~x; in_amt = 6'd63;
        @(negedge clk);
        check("R9 valid low", {63'd0, out_valid}, 64'd0);
        check("R9 data held", out_data, ref_op(2'd0, 6'd8, x));

        // R6: round trips of shuffle then unshuffle
        for (int i = 0; i < 40; i++) begin
            logic [5:0] a;
            x = {$urandom, $urandom};
            a = 6'($urandom);
            y = ref_op(2'd2, a, x);
            run("R5 shfl", 2'd2, a, x, y);
            run("R6 round trip", 2'd3, a, y, x);
        end

        // R1..R5 random mix, back to back
        @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            logic [1:0]  op;
            logic [5:0]  a;
            logic [63:0] d;
            op = 2'($urandom);
            a  = 6'($urandom);
            d  = {$urandom, $urandom};
            in_valid = 1'b1; in_op = op; in_amt = a; in_data = d;
            @(negedge clk);
            check("R1 random valid", {63'd0, out_valid}, 64'd1);
            check("R1 random data", out_data, ref_op(op, a, d));
        end
        in_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule